// File: doc/BRIEF.md
# Reply Queue Steering Selector

This block picks a reply queue for every new I/O request. The queue space is split into two parts. A small group of queues at the low indices has interrupt coalescing switched on. The remaining queues are low-latency queues, and each one belongs to a processor. The choice for a request depends on how many requests are already in flight to its target device. A device with a shallow backlog is served on the low-latency queue of the processor that issued the request. A device with a deep backlog is sent to the coalescing group. That group is walked round-robin, and each queue takes a fixed batch of requests before the pointer moves on.

Per-device in-flight counters rise on each submit and fall on each completion. A single batch counter and queue pointer are shared by all devices. When the high-throughput mode is off, the coalescing group is never used, and every request follows a plain per-processor mapping. A two-state mode machine drives the block. State ST_LEGACY is entered from reset and through transition T_DISABLE whenever `ht_en` is low. State ST_BALANCED is entered through transition T_ENABLE whenever `ht_en` is high. While the next state is ST_LEGACY, the shared batch counter and pointer are held at zero. The result for a request is registered and appears on the cycle after the request.

Top module: `reply_queue_steer`

## Requirements
- R1: One cycle after a clock edge that sees `req_valid` high, `sel_valid` is high. After an edge that sees `req_valid` low, `sel_valid` is low. Reset clears `sel_valid`.
- R2: `sel_coalesced` is 1 exactly when the chosen queue is in the coalescing group (indices 0 to 7). Low-latency choices always have an index of 8 or more.
- R3: With `ht_en` = 1 and fewer than 120 processors online, a request to a device with 8 or fewer requests in flight goes to queue 8 + `cpu_idx`. `cpu_idx` is less than `cpus_online`.
- R4: With `ht_en` = 1 and 120 or more processors online, a shallow-device request goes to queue 8 + (`cpu_idx` mod 120). The low-latency span is therefore queues 8 to 127.
- R5: With `ht_en` = 1, a request to a device with more than 8 requests in flight goes to the current coalescing pointer. The pointer starts at 0 and moves to the next queue after every 16th such request. After queue 7 it wraps to 0.
- R6: The batch counter and pointer are shared by all devices. A deep request from any device continues the same sequence.
- R7: With `ht_en` = 0, a request goes to queue `cpu_idx` when fewer than 128 processors are online. Otherwise it goes to queue `cpu_idx` mod 128. `sel_coalesced` is 0 whatever the device depth.
- R8: A clock edge with `ht_en` = 0 resets the batch counter and pointer. The next deep request after re-enabling goes to queue 0 and starts a fresh batch of 16.
- R9: A device's in-flight count rises by one on submit and falls by one on completion. A completion at zero leaves it at zero. A submit and a completion to the same device on the same edge leave it unchanged.
- R10: The depth test uses the count held before the edge that takes the request. The 10th back-to-back submit to an idle device is the first to be treated as deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request strobe |
| req_dev | input | DEV_W | Target device of the request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_dev | input | DEV_W | Device whose request completed |
| ht_en | input | 1 | High-throughput mode enable |
| cpus_online | input | CPU_W | Number of online processors |
| cpu_idx | input | CPU_W | Index of the issuing processor |
| sel_valid | output | 1 | Selection result valid |
| sel_queue | output | Q_W | Selected reply queue index |
| sel_coalesced | output | 1 | Selected queue has coalescing on |

## Verification
The bench sweeps every processor index at processor counts below, at and above the 120 and 128 limits. This catches a fold applied at the wrong limit, which would send high indices to wrong or out-of-range queues. It pushes one device through the depth boundary one request at a time, so an off-by-one or post-update depth test shows up as the 9th or 11th request being coalesced. It runs long deep streams across several devices and through a mode toggle. A per-device pointer, a wrong batch length, a missing wrap or a missed clear would all shift the queue sequence. It also drains a counter well past zero, and a counter that wrapped below zero would turn an idle device deep at once.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

    // Mode machine states: coalescing group unused / in use.
    typedef enum logic [0:0] {
        ST_LEGACY   = 1'b0,
        ST_BALANCED = 1'b1
    } mode_e;

    // Routing decision for the request on the current edge.
    typedef enum logic [1:0] {
        RT_NONE     = 2'd0,
        RT_LEGACY   = 2'd1,
        RT_LOWLAT   = 2'd2,
        RT_COALESCE = 2'd3
    } route_e;

endpackage

// File: rtl/rqs_depth_track.sv
module rqs_depth_track #(
    parameter int NUM_DEV     = 16,
    parameter int CNT_W       = 8,
    parameter int DEEP_THRESH = 8,
    localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [DEV_W-1:0] inc_dev,
    input  logic             dec,
    input  logic [DEV_W-1:0] dec_dev,
    input  logic [DEV_W-1:0] rd_dev,
    output logic             deep
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic inc_hit;
        logic dec_hit;

        assign inc_hit = inc && (inc_dev == DEV_W'(d));
        assign dec_hit = dec && (dec_dev == DEV_W'(d));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[d] <= '0;
            end else if (inc_hit && !dec_hit && cnt_q[d] != CNT_MAX) begin
                cnt_q[d] <= cnt_q[d] + 1'b1;
            end else if (dec_hit && !inc_hit && cnt_q[d] != '0) begin
                cnt_q[d] <= cnt_q[d] - 1'b1;
            end
        end

        // R9: a completion on an idle device keeps it at zero
        a_r9_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[d] == '0 && dec_hit && !inc_hit) |=> (cnt_q[d] == '0));

        // R9: submit and completion on the same edge cancel
        a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_hit && dec_hit) |=> $stable(cnt_q[d]));
    end

    // R10: depth is judged on the count held before this edge's update
    assign deep = cnt_q[rd_dev] > CNT_W'(DEEP_THRESH);

endmodule

// File: rtl/rqs_batch_rr.sv
module rqs_batch_rr #(
    parameter int HT_Q       = 8,
    parameter int BATCH      = 16,
    localparam int PTR_W     = (HT_Q > 1) ? $clog2(HT_Q) : 1,
    localparam int BC_W      = (BATCH > 1) ? $clog2(BATCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(BATCH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(HT_Q - 1);

    logic [BC_W-1:0]  bcnt_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bcnt_q <= '0;
            ptr_q  <= '0;
        end else if (adv) begin
            if (bcnt_q == BC_LAST) begin
                bcnt_q <= '0;
                ptr_q  <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    assign ptr = ptr_q;

    // R5: the pointer only moves at the end of a batch or on a clear
    a_r5_step_at_batch_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> ($past(clear) || $past(bcnt_q) == BC_LAST));

    // R8: a clear leaves both the pointer and the batch count at zero
    a_r8_clear_home: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr_q == '0 && bcnt_q == '0));

endmodule

// File: rtl/rqs_ll_map.sv
module rqs_ll_map #(
    parameter int CPU_W = 8,
    parameter int MAX_Q = 128,
    parameter int HT_Q  = 8,
    localparam int Q_W  = $clog2(MAX_Q)
) (
    input  logic             ht_en,
    input  logic [CPU_W-1:0] cpus_online,
    input  logic [CPU_W-1:0] cpu_idx,
    output logic [Q_W-1:0]   ll_queue
);

    localparam int LL_SPAN = MAX_Q - HT_Q;

    logic [CPU_W-1:0] bal_idx;
    logic [CPU_W-1:0] leg_idx;

    always_comb begin
        // Balanced: one low-latency queue per processor, folded past the span
        if (cpus_online >= CPU_W'(LL_SPAN)) begin
            bal_idx = cpu_idx % CPU_W'(LL_SPAN);
        end else begin
            bal_idx = cpu_idx;
        end
        // Legacy: whole queue space per processor, folded past the maximum
        if (cpus_online >= CPU_W'(MAX_Q)) begin
            leg_idx = cpu_idx % CPU_W'(MAX_Q);
        end else begin
            leg_idx = cpu_idx;
        end
        if (ht_en) begin
            ll_queue = Q_W'(bal_idx) + Q_W'(HT_Q);
        end else begin
            ll_queue = Q_W'(leg_idx);
        end
    end

endmodule

// File: rtl/reply_queue_steer.sv
module reply_queue_steer
    import rqs_pkg::*;
#(
    parameter int NUM_DEV     = 16,
    parameter int CNT_W       = 8,
    parameter int CPU_W       = 8,
    parameter int MAX_Q       = 128,
    parameter int HT_Q        = 8,
    parameter int BATCH       = 16,
    parameter int DEEP_THRESH = 8,
    localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int Q_W        = $clog2(MAX_Q),
    localparam int PTR_W      = (HT_Q > 1) ? $clog2(HT_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DEV_W-1:0] req_dev,
    input  logic             cpl_valid,
    input  logic [DEV_W-1:0] cpl_dev,
    input  logic             ht_en,
    input  logic [CPU_W-1:0] cpus_online,
    input  logic [CPU_W-1:0] cpu_idx,
    output logic             sel_valid,
    output logic [Q_W-1:0]   sel_queue,
    output logic             sel_coalesced
);

    mode_e            state_q, state_d;
    route_e           route;
    logic             deep;
    logic [PTR_W-1:0] ht_ptr;
    logic [Q_W-1:0]   ll_q;
    logic [Q_W-1:0]   pick_q;

    logic             sel_valid_q;
    logic [Q_W-1:0]   sel_queue_q;
    logic             sel_coal_q;

    rqs_depth_track #(
        .NUM_DEV     (NUM_DEV),
        .CNT_W       (CNT_W),
        .DEEP_THRESH (DEEP_THRESH)
    ) u_depth (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (req_valid),
        .inc_dev (req_dev),
        .dec     (cpl_valid),
        .dec_dev (cpl_dev),
        .rd_dev  (req_dev),
        .deep    (deep)
    );

    rqs_batch_rr #(
        .HT_Q  (HT_Q),
        .BATCH (BATCH)
    ) u_batch (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d == ST_LEGACY),
        .adv   (route == RT_COALESCE),
        .ptr   (ht_ptr)
    );

    rqs_ll_map #(
        .CPU_W (CPU_W),
        .MAX_Q (MAX_Q),
        .HT_Q  (HT_Q)
    ) u_llmap (
        .ht_en       (ht_en),
        .cpus_online (cpus_online),
        .cpu_idx     (cpu_idx),
        .ll_queue    (ll_q)
    );

    // Mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LEGACY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_ENABLE (LEGACY->BALANCED), T_DISABLE (BALANCED->LEGACY)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEGACY:   if (ht_en)  state_d = ST_BALANCED;
            ST_BALANCED: if (!ht_en) state_d = ST_LEGACY;
            default:     state_d = ST_LEGACY;
        endcase
    end

    // Output decision for the request on this edge
    always_comb begin
        route = RT_NONE;
        if (req_valid) begin
            unique case (state_d)
                ST_LEGACY:   route = RT_LEGACY;
                ST_BALANCED: route = deep ? RT_COALESCE : RT_LOWLAT;
                default:     route = RT_LEGACY;
            endcase
        end
        pick_q = (route == RT_COALESCE) ? Q_W'(ht_ptr) : ll_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_queue_q <= '0;
            sel_coal_q  <= 1'b0;
        end else begin
            sel_valid_q <= (route != RT_NONE);
            sel_queue_q <= (route != RT_NONE) ? pick_q : sel_queue_q;
            sel_coal_q  <= (route == RT_COALESCE);
        end
    end

    assign sel_valid     = sel_valid_q;
    assign sel_queue     = sel_queue_q;
    assign sel_coalesced = sel_coal_q;

    // R1: a request gives a result exactly one cycle later
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> sel_valid);

    // R1: no request, no result
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !sel_valid);

    // R2: coalesced results stay inside the coalescing group
    a_r2_coal_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_coalesced |-> (sel_queue < Q_W'(HT_Q)));

    // R2: low-latency results in balanced mode stay above the group
    a_r2_lowlat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ht_en) |=> (sel_coalesced || sel_queue >= Q_W'(HT_Q)));

    // R7: legacy mode never yields a coalesced result
    a_r7_legacy_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ht_en) |=> !sel_coalesced);

endmodule

// File: tb/sim_reply_queue_steer.sv
module sim_reply_queue_steer;

    localparam int NDEV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_dev = '0;
    logic       cpl_valid = 1'b0;
    logic [1:0] cpl_dev = '0;
    logic       ht_en = 1'b0;
    logic [7:0] cpus_online = 8'd1;
    logic [7:0] cpu_idx = '0;
    logic       sel_valid;
    logic [6:0] sel_queue;
    logic       sel_coalesced;

    int checks = 0;
    int fails  = 0;
    int cnt [NDEV];
    int ptr = 0;
    int bc  = 0;

    always #10 clk = ~clk;

    reply_queue_steer #(.NUM_DEV(NDEV)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dev       (req_dev),
        .cpl_valid     (cpl_valid),
        .cpl_dev       (cpl_dev),
        .ht_en         (ht_en),
        .cpus_online   (cpus_online),
        .cpu_idx       (cpu_idx),
        .sel_valid     (sel_valid),
        .sel_queue     (sel_queue),
        .sel_coalesced (sel_coalesced)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, predict, check at the following negedge.
    task automatic step(input bit rq, input int dv, input bit cp, input int cd,
                        input int cpu, input bit ht, input int ncpu, input string tag);
        int  exp_q = 0;
        bit  exp_c = 0;
        bit  adv   = 0;
        string t;
        req_valid   = rq;
        req_dev     = 2'(dv);
        cpl_valid   = cp;
        cpl_dev     = 2'(cd);
        cpu_idx     = 8'(cpu);
        ht_en       = ht;
        cpus_online = 8'(ncpu);
        t = tag;
        if (rq) begin
            if (!ht) begin
                exp_q = (ncpu >= 128) ? cpu % 128 : cpu;
                if (t == "") t = "R7";
            end else if (cnt[dv] > 8) begin
                exp_q = ptr; exp_c = 1; adv = 1;
                if (t == "") t = "R5";
            end else begin
                exp_q = 8 + ((ncpu >= 120) ? cpu % 120 : cpu);
                if (t == "") t = (ncpu >= 120) ? "R4" : "R3";
            end
        end
        // model update
        if (!(rq && cp && dv == cd)) begin
            if (rq && cnt[dv] < 255) cnt[dv]++;
            if (cp && cnt[cd] > 0) cnt[cd]--;
        end
        if (!ht) begin
            ptr = 0; bc = 0;
        end else if (adv) begin
            bc++;
            if (bc == 16) begin bc = 0; ptr = (ptr + 1) % 8; end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1 valid", int'(sel_valid), int'(rq));
        if (rq) begin
            chk(t, int'(sel_queue), exp_q);
            chk("R2 coalesced flag", int'(sel_coalesced), int'(exp_c));
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NDEV; i++) cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", int'(sel_valid), 0);
        chk("R1 reset coalesced", int'(sel_coalesced), 0);
        step(0, 0, 0, 0, 0, 1, 72, "R1");

        // R3 / R4: shallow device (submit and completion cancel, R9)
        for (int c = 0; c < 72; c++)  step(1, 0, 1, 0, c, 1, 72, "");
        for (int c = 0; c < 120; c++) step(1, 0, 1, 0, c, 1, 120, "");
        for (int c = 0; c < 200; c++) step(1, 0, 1, 0, c, 1, 200, "");
        // R7: legacy mapping below, at and above 128 processors
        for (int c = 0; c < 72; c++)  step(1, 0, 1, 0, c, 0, 72, "");
        for (int c = 0; c < 128; c++) step(1, 0, 1, 0, c, 0, 128, "");
        for (int c = 0; c < 200; c++) step(1, 0, 1, 0, c, 0, 200, "");
        chk("R9 cancel keeps dev0 idle", cnt[0], 0);

        // R10: depth boundary on device 1
        for (int k = 0; k < 9; k++) step(1, 1, 0, 0, 3, 1, 16, "R10 shallow");
        step(1, 1, 0, 0, 3, 1, 16, "R10 first deep");
        // R5: long stream through a full wrap of the pointer
        for (int k = 0; k < 139; k++) step(1, 1, 0, 0, 3, 1, 16, "");
        step(0, 0, 0, 0, 0, 1, 16, "R1");

        // R6: device 2 becomes deep and shares the sequence
        for (int k = 0; k < 9; k++) step(1, 2, 0, 0, 5, 1, 16, "");
        for (int k = 0; k < 40; k++) step(1, 1 + (k % 2), 0, 0, 5, 1, 16, "R6");

        // R7 with a deep device, then R8: pointer restarts after re-enable
        step(1, 1, 0, 0, 6, 0, 16, "R7 deep legacy");
        for (int k = 0; k < 20; k++) step(1, 2, 0, 0, 6, 1, 16, "R8");

        // R9: drain device 1 far below zero, then refill
        for (int k = 0; k < 250; k++) step(0, 0, 1, 1, 0, 1, 16, "R9");
        for (int k = 0; k < 9; k++) step(1, 1, 0, 0, 7, 1, 16, "R9 floor");
        step(1, 1, 0, 0, 7, 1, 16, "R9 deep again");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule